// File: doc/BRIEF.md
# Banked Serial-Controller Register Interface

This block is the host-facing register file and address decoder of a classic byte-wide serial controller. A processor reaches it over a simple synchronous bus: a byte address whose registers sit on word (four-byte) spacing, a write strobe, a read strobe, write data and registered read data. The decoder picks a target from three things: the word offset, whether the access is a read or a write, and a bank-select bit held in the block's own line-control register. As a result, a handful of addresses expose more registers than there are offsets.

With the bank bit clear, the data offset is a transmit register on writes and a receive register on reads, and the next offset is the interrupt-enable register. With the bank bit set, those two offsets become the low and high bytes of the 16-bit baud divisor. A divisor write issued while the bank bit is clear reaches the transmit or interrupt-enable register instead, and the divisor is left as it was. Transmit writes leave the block as a one-cycle strobe with a byte. Receive reads raise a one-cycle pop strobe toward the receive stub. Line status and interrupt identification come in as inputs, and the FIFO-control value goes out as an output.

Top module: `sercsr_top`

## Requirements
- R1: After reset, line control, interrupt enable, FIFO control and read data are zero, both strobes are low, and the divisor equals the parameter DIV_RESET (default 0x000C).
- R2: With the bank bit clear, a write to offset 0x0 makes tx_valid high for exactly the following cycle, with tx_byte equal to write data bits 7:0.
- R3: With the bank bit clear, a read of offset 0x0 returns rx_byte and makes rx_pop high for exactly the following cycle.
- R4: With the bank bit clear, offset 0x4 reads and writes the 8-bit interrupt-enable register.
- R5: With the bank bit set, offset 0x0 reads and writes divisor bits 7:0 and offset 0x4 reads and writes divisor bits 15:8. Neither access raises tx_valid or rx_pop.
- R6: While the bank bit is clear, no bus access changes the divisor.
- R7: Offset 0xC is a read/write line-control register whose bit 7 is the bank bit. Writing 0x80 enters the divisor bank, and writing 0x03 leaves it.
- R8: Offset 0x8 returns the irq_id input on reads and loads fifo_ctrl on writes. A read never returns fifo_ctrl, and a read never changes it.
- R9: Offset 0x14 returns the line_status input on reads. Writes to it change no register and raise no strobe.
- R10: Reads of unmapped offsets (0x10, 0x18, 0x1C) return zero. Writes to them have no effect. Address bits 1:0 are ignored.
- R11: Read data appears in the cycle after the read and holds until the next read. An access with both strobes high is a write only: rdata holds and rx_pop stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data (bits 7:0 used) |
| bus_rdata | output | DATA_W | Registered read data, zero-extended byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_byte | input | 8 | Byte offered by the receive stub |
| rx_pop | output | 1 | One-cycle receive pop strobe |
| irq_id | input | 8 | Interrupt identification from the core |
| line_status | input | 8 | Hardware line status |
| divisor | output | 16 | Baud divisor latches |
| int_enable | output | 8 | Interrupt-enable register |
| line_ctrl | output | 8 | Line-control register |
| fifo_ctrl | output | 8 | Last FIFO-control write |

## Verification
The embedded properties check on every cycle that the divisor holds while the bank bit is clear. They also check that transmit and pop strobes only follow accesses made with the bank bit clear, and that the two strobes are never high together. Finally, they check that line control, FIFO control and read data change only after a write or read respectively. The bench scenarios are the only place where data routing shows: which byte lands in which register, the divisor-before-bank mistake hitting transmit and interrupt enable, the reads of line status and identification, and the zero returned by unmapped offsets.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;

    localparam int BYTE_W   = 8;
    localparam int BANK_BIT = 7;

    localparam logic [2:0] IDX_DATA = 3'd0;
    localparam logic [2:0] IDX_IEN  = 3'd1;
    localparam logic [2:0] IDX_ID   = 3'd2;
    localparam logic [2:0] IDX_LCT  = 3'd3;
    localparam logic [2:0] IDX_LST  = 3'd5;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TXD,
        SEL_RXD,
        SEL_DLO,
        SEL_DHI,
        SEL_IEN,
        SEL_IID,
        SEL_FCT,
        SEL_LCT,
        SEL_LST
    } sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lcr;
        logic [BYTE_W-1:0] ier;
        logic [BYTE_W-1:0] fcr;
        logic [BYTE_W-1:0] dlo;
        logic [BYTE_W-1:0] dhi;
        logic              tx_v;
        logic [BYTE_W-1:0] tx_b;
        logic              pop;
    } csr_state_t;

endpackage

// File: rtl/sercsr_decode.sv
module sercsr_decode
    import sercsr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              bank,
    output sel_e              sel,
    output logic              is_wr,
    output logic              is_rd
);

    logic       hi_zero;
    logic [2:0] idx;

    generate
        if (ADDR_W > 5) begin : g_hi
            assign hi_zero = ~|addr[ADDR_W-1:5];
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign idx   = addr[4:2];
    assign is_wr = wr;
    assign is_rd = rd & ~wr;

    always_comb begin
        sel = SEL_NONE;
        if ((wr | rd) && hi_zero) begin
            unique case (idx)
                IDX_DATA: sel = bank ? SEL_DLO : (wr ? SEL_TXD : SEL_RXD);
                IDX_IEN:  sel = bank ? SEL_DHI : SEL_IEN;
                IDX_ID:   sel = wr ? SEL_FCT : SEL_IID;
                IDX_LCT:  sel = SEL_LCT;
                IDX_LST:  sel = wr ? SEL_NONE : SEL_LST;
                default:  sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sercsr_regs.sv
module sercsr_regs
    import sercsr_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter logic [15:0] DIV_RESET = 16'h000C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sel_e              sel,
    input  logic              is_wr,
    input  logic              is_rd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] irq_id,
    input  logic [BYTE_W-1:0] line_status,
    output logic [DATA_W-1:0] rdata,
    output csr_state_t        state,
    output logic              bank
);

    localparam int PAD_W = DATA_W - BYTE_W;

    csr_state_t        q, d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [BYTE_W-1:0] rbyte;

    always_comb begin
        d       = q;
        d.tx_v  = 1'b0;
        d.pop   = 1'b0;
        rdata_d = rdata_q;
        rbyte   = '0;
        if (is_wr) begin
            unique case (sel)
                SEL_TXD: begin
                    d.tx_v = 1'b1;
                    d.tx_b = wbyte;
                end
                SEL_DLO: d.dlo = wbyte;
                SEL_DHI: d.dhi = wbyte;
                SEL_IEN: d.ier = wbyte;
                SEL_FCT: d.fcr = wbyte;
                SEL_LCT: d.lcr = wbyte;
                default: ;
            endcase
        end else if (is_rd) begin
            unique case (sel)
                SEL_RXD: begin
                    rbyte = rx_byte;
                    d.pop = 1'b1;
                end
                SEL_DLO: rbyte = q.dlo;
                SEL_DHI: rbyte = q.dhi;
                SEL_IEN: rbyte = q.ier;
                SEL_IID: rbyte = irq_id;
                SEL_LCT: rbyte = q.lcr;
                SEL_LST: rbyte = line_status;
                default: rbyte = '0;
            endcase
            rdata_d = {{PAD_W{1'b0}}, rbyte};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '{lcr: '0, ier: '0, fcr: '0,
                         dlo: DIV_RESET[7:0], dhi: DIV_RESET[15:8],
                         tx_v: 1'b0, tx_b: '0, pop: 1'b0};
            rdata_q <= '0;
        end else begin
            q       <= d;
            rdata_q <= rdata_d;
        end
    end

    assign state = q;
    assign rdata = rdata_q;
    assign bank  = q.lcr[BANK_BIT];

    // R6
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(q.lcr[BANK_BIT]) |-> $stable({q.dhi, q.dlo}));

    // R2
    tx_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tx_v |-> !$past(q.lcr[BANK_BIT]));

    // R3
    pop_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pop |-> !$past(q.lcr[BANK_BIT]));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.tx_v && q.pop));

    // R8
    fcr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(is_wr) |-> $stable(q.fcr));

    // R7
    lcr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(is_wr) |-> $stable(q.lcr));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(is_rd) |-> $stable(rdata_q));

endmodule

// File: rtl/sercsr_top.sv
module sercsr_top
    import sercsr_pkg::*;
#(
    parameter int          ADDR_W    = 5,
    parameter int          DATA_W    = 32,
    parameter logic [15:0] DIV_RESET = 16'h000C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic [7:0]        rx_byte,
    output logic              rx_pop,
    input  logic [7:0]        irq_id,
    input  logic [7:0]        line_status,
    output logic [15:0]       divisor,
    output logic [7:0]        int_enable,
    output logic [7:0]        line_ctrl,
    output logic [7:0]        fifo_ctrl
);

    sel_e       sel;
    logic       is_wr;
    logic       is_rd;
    logic       bank;
    csr_state_t st;

    sercsr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .bank  (bank),
        .sel   (sel),
        .is_wr (is_wr),
        .is_rd (is_rd)
    );

    sercsr_regs #(.DATA_W(DATA_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .is_wr       (is_wr),
        .is_rd       (is_rd),
        .wbyte       (bus_wdata[7:0]),
        .rx_byte     (rx_byte),
        .irq_id      (irq_id),
        .line_status (line_status),
        .rdata       (bus_rdata),
        .state       (st),
        .bank        (bank)
    );

    assign tx_valid   = st.tx_v;
    assign tx_byte    = st.tx_b;
    assign rx_pop     = st.pop;
    assign divisor    = {st.dhi, st.dlo};
    assign int_enable = st.ier;
    assign line_ctrl  = st.lcr;
    assign fifo_ctrl  = st.fcr;

endmodule

// File: tb/sercsr_top_test.sv
module sercsr_top_test;

    localparam int          AW   = 5;
    localparam int          DW   = 32;
    localparam logic [15:0] DIVR = 16'h000C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          tx_valid;
    logic [7:0]    tx_byte;
    logic [7:0]    rx_byte = 8'h00;
    logic          rx_pop;
    logic [7:0]    irq_id = 8'h01;
    logic [7:0]    line_status = 8'h60;
    logic [15:0]   divisor;
    logic [7:0]    int_enable;
    logic [7:0]    line_ctrl;
    logic [7:0]    fifo_ctrl;

    sercsr_top #(.ADDR_W(AW), .DATA_W(DW), .DIV_RESET(DIVR)) uut (.*);

    always #10 clk = ~clk;

    typedef struct {
        logic [31:0] rd;
        logic        tx;
        logic [7:0]  tb;
        logic        pop;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] held = '0;
    logic        fire = 1'b0;
    bit          done = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(logic w, logic r, logic [AW-1:0] a, logic [31:0] wd,
                          logic [31:0] erd, logic etx, logic [7:0] etb,
                          logic epop, string tag);
        item_t it;
        it.rd = erd; it.tx = etx; it.tb = etb; it.pop = epop; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = wd;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] wd, logic etx, string tag);
        access(1'b1, 1'b0, a, wd, held, etx, wd[7:0], 1'b0, tag);
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] exp, logic epop, string tag);
        held = exp;
        access(1'b0, 1'b1, a, '0, exp, 1'b0, 8'h00, epop, tag);
    endtask

    // monitor: flags an accepted access, then compares at the following negedge
    always @(posedge clk) fire = rst_n && (bus_wr || bus_rd);

    always @(negedge clk) begin
        if (fire) begin
            if (sbq.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual access expected none");
            end else begin
                item_t it;
                it = sbq.pop_front();
                chk({it.tag, " rdata"}, bus_rdata, it.rd);
                chk({it.tag, " tx_valid"}, {31'b0, tx_valid}, {31'b0, it.tx});
                if (it.tx) chk({it.tag, " tx_byte"}, {24'b0, tx_byte}, {24'b0, it.tb});
                chk({it.tag, " rx_pop"}, {31'b0, rx_pop}, {31'b0, it.pop});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        chk("R1 rx_pop", {31'b0, rx_pop}, 32'h0);
        chk("R1 divisor", {16'b0, divisor}, {16'b0, DIVR});
        chk("R1 line_ctrl", {24'b0, line_ctrl}, 32'h0);
        chk("R1 int_enable", {24'b0, int_enable}, 32'h0);
        chk("R1 fifo_ctrl", {24'b0, fifo_ctrl}, 32'h0);

        // R2 transmit write with bank clear
        wr(5'h00, 32'h41, 1'b1, "R2 tx write");
        chk("R6 divisor after tx", {16'b0, divisor}, {16'b0, DIVR});
        @(negedge clk);
        chk("R2 strobe single", {31'b0, tx_valid}, 32'h0);

        // R3 receive read with bank clear
        rx_byte = 8'h5A;
        rd(5'h00, 32'h5A, 1'b1, "R3 rx read");
        @(negedge clk);
        chk("R3 pop single", {31'b0, rx_pop}, 32'h0);

        // R4 interrupt enable
        wr(5'h04, 32'h02, 1'b0, "R4 ier write");
        chk("R4 int_enable", {24'b0, int_enable}, 32'h02);
        rd(5'h04, 32'h02, 1'b0, "R4 ier read");

        // R6 divisor written without entering the bank
        wr(5'h00, 32'h68, 1'b1, "R6 stray low");
        wr(5'h04, 32'h00, 1'b0, "R6 stray high");
        chk("R6 divisor untouched", {16'b0, divisor}, {16'b0, DIVR});
        chk("R6 ier overwritten", {24'b0, int_enable}, 32'h00);
        wr(5'h04, 32'h02, 1'b0, "R4 ier restore");

        // R7 enter bank, R5 divisor access
        wr(5'h0C, 32'h80, 1'b0, "R7 enter bank");
        chk("R7 line_ctrl", {24'b0, line_ctrl}, 32'h80);
        rd(5'h0C, 32'h80, 1'b0, "R7 lcr read");
        wr(5'h00, 32'h68, 1'b0, "R5 div low");
        wr(5'h04, 32'h01, 1'b0, "R5 div high");
        chk("R5 divisor", {16'b0, divisor}, 32'h0168);
        chk("R5 ier kept", {24'b0, int_enable}, 32'h02);
        rd(5'h00, 32'h68, 1'b0, "R5 div low read");
        rd(5'h04, 32'h01, 1'b0, "R5 div high read");
        wr(5'h0C, 32'h03, 1'b0, "R7 leave bank");
        chk("R7 line_ctrl 8N1", {24'b0, line_ctrl}, 32'h03);
        rd(5'h04, 32'h02, 1'b0, "R7 ier view back");
        rx_byte = 8'hA5;
        rd(5'h00, 32'hA5, 1'b1, "R7 rx view back");

        // R8 identification and FIFO control
        wr(5'h08, 32'hC7, 1'b0, "R8 fcr write");
        chk("R8 fifo_ctrl", {24'b0, fifo_ctrl}, 32'hC7);
        irq_id = 8'hC1;
        rd(5'h08, 32'hC1, 1'b0, "R8 iid read");
        chk("R8 fifo_ctrl after read", {24'b0, fifo_ctrl}, 32'hC7);

        // R9 line status
        wr(5'h14, 32'hFF, 1'b0, "R9 lsr write");
        chk("R9 line_ctrl kept", {24'b0, line_ctrl}, 32'h03);
        chk("R9 fifo_ctrl kept", {24'b0, fifo_ctrl}, 32'hC7);
        chk("R9 ier kept", {24'b0, int_enable}, 32'h02);
        chk("R9 divisor kept", {16'b0, divisor}, 32'h0168);
        line_status = 8'h21;
        rd(5'h14, 32'h21, 1'b0, "R9 lsr read");

        // R10 unmapped offsets and ignored low address bits
        rd(5'h10, 32'h0, 1'b0, "R10 read 0x10");
        wr(5'h18, 32'hFF, 1'b0, "R10 write 0x18");
        chk("R10 line_ctrl kept", {24'b0, line_ctrl}, 32'h03);
        chk("R10 divisor kept", {16'b0, divisor}, 32'h0168);
        chk("R10 ier kept", {24'b0, int_enable}, 32'h02);
        rd(5'h1C, 32'h0, 1'b0, "R10 read 0x1C");
        rd(5'h0F, 32'h03, 1'b0, "R10 low bits ignored");

        // R11 write wins over a simultaneous read
        access(1'b1, 1'b1, 5'h00, 32'h33, held, 1'b1, 8'h33, 1'b0, "R11 wr+rd");
        @(negedge clk);
        chk("R11 rdata held", bus_rdata, 32'h03);

        repeat (2) @(negedge clk);
        chk("R11 scoreboard drained", sbq.size(), 32'h0);
        finish_run();
    end

endmodule